// File: doc/BRIEF.md
# Threefish-256 Eight-Round Group Core

This block applies one group of eight consecutive Threefish-256 rounds to a 256-bit state in a single clock cycle. The state is four 64-bit words. Each round mixes two word pairs and then reorders the words. A 256-bit subkey is added word by word before the first round of the group and another before the fifth. The group always starts at a round index that is a multiple of eight, so every rotation distance is a hard-wired constant. The result depends only on the state and the two subkeys that arrive with it.

A surrounding controller supplies the subkeys, applies the group nine times per block, and handles the key schedule, the tweak and the final subkey. Operands enter through a valid/ready port and leave through a valid/ready port with one register stage between them. An input beat is taken when `in_valid` and `in_ready` are both high. A result beat is consumed when `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. This gives full throughput with one-cycle latency. While the consumer holds `out_ready` low, the result is frozen and upstream is stalled.

Top module: `tf8_core`

## Requirements
- R1: While reset (`rst_n`, asynchronous, active low) is asserted and in the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: Word i of a 256-bit bus occupies bits [64i+63:64i]. MIX of a pair (a, b) gives a' = (a + b) mod 2^64 and b' = rotl(b, r) XOR a'. The pairs are words (0,1) and (2,3).
- R3: Rotation distances for pair (0,1) and pair (2,3) in rounds 0 to 7 of the group are (14,16), (52,57), (23,40), (5,37), (25,33), (46,12), (58,22), (32,32).
- R4: After each MIX layer, words 1 and 3 swap places and words 0 and 2 stay in place.
- R5: `in_sk0` is added to the state before round 0 and `in_sk1` before round 4. Each addition is per word modulo 2^64, and no carry passes between words. No subkey is added after round 7.
- R6: A beat accepted at a clock edge shows up as `out_valid` = 1 with `out_state` = the eight-round result immediately after that edge, one cycle of latency.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1, `out_state` keeps its value and `in_ready` is 0.
- R8: `in_ready` is 1 when `out_valid` is 0, or when `out_ready` is 1. A new beat can then be accepted in the same cycle in which the old result drains.
- R9: An all-zero state with all-zero subkeys gives an all-zero result. A state whose words are cancelled by `in_sk0` (sum 0 mod 2^64 per word), together with a zero `in_sk1`, also gives an all-zero result.
- R10: `in_valid` and the operand inputs have no effect while `in_ready` is 0. When the output drains with no new beat, `out_valid` falls after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Core can take an operand beat |
| in_state | input | 256 | State in, word i at bits [64i+63:64i] |
| in_sk0 | input | 256 | Subkey added before round 0 |
| in_sk1 | input | 256 | Subkey added before round 4 |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_state | output | 256 | State after eight rounds |

## Verification
The bench builds the core with its default 64-bit word width. At that width the full rotation table is exercised, and so is wraparound of the 2^64 additions in both the MIX adders and the subkey adders. The ordering of the permutation across all eight rounds is also checked. A behavioural round loop in the bench acts as the reference for a fixed table of patterns and for a run of random operands. Two vectors cancel to zero and can be checked without the model. Directed stalls with `out_ready` low reach the hold, ignore and same-cycle drain-and-refill cases of the handshake.

// File: rtl/tf8_pkg.sv
package tf8_pkg;
  localparam int GROUP_ROUNDS = 8;
  localparam int KEY_STRIDE   = 4;
  localparam int NUM_WORDS    = 4;

  // rotation distance for round d of the group, pair 0 = words (0,1), pair 1 = words (2,3)
  function automatic int rot_dist(input int d, input int pair);
    int r;
    case (d % GROUP_ROUNDS)
      0: r = (pair == 0) ? 14 : 16;
      1: r = (pair == 0) ? 52 : 57;
      2: r = (pair == 0) ? 23 : 40;
      3: r = (pair == 0) ? 5  : 37;
      4: r = (pair == 0) ? 25 : 33;
      5: r = (pair == 0) ? 46 : 12;
      6: r = (pair == 0) ? 58 : 22;
      default: r = 32;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tf8_mix.sv
module tf8_mix #(
  parameter int W   = 64,
  parameter int ROT = 14
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o
);
  logic [W-1:0] sum;
  logic [W-1:0] rot;

  assign sum = a_i + b_i;
  assign rot = (b_i << ROT) | (b_i >> (W - ROT));
  assign a_o = sum;
  assign b_o = rot ^ sum;
endmodule

// File: rtl/tf8_keyadd.sv
module tf8_keyadd #(
  parameter int W = 64,
  parameter int N = 4
) (
  input  logic [N*W-1:0] st_i,
  input  logic [N*W-1:0] key_i,
  output logic [N*W-1:0] st_o
);
  for (genvar i = 0; i < N; i++) begin : g_word
    assign st_o[i*W +: W] = st_i[i*W +: W] + key_i[i*W +: W];
  end
endmodule

// File: rtl/tf8_round.sv
module tf8_round #(
  parameter int W    = 64,
  parameter int RIDX = 0
) (
  input  logic [4*W-1:0] st_i,
  output logic [4*W-1:0] st_o
);
  localparam int ROT_A = tf8_pkg::rot_dist(RIDX, 0);
  localparam int ROT_B = tf8_pkg::rot_dist(RIDX, 1);

  logic [W-1:0] m0, m1, m2, m3;

  tf8_mix #(.W(W), .ROT(ROT_A)) u_mix_a (
    .a_i(st_i[0*W +: W]), .b_i(st_i[1*W +: W]), .a_o(m0), .b_o(m1)
  );
  tf8_mix #(.W(W), .ROT(ROT_B)) u_mix_b (
    .a_i(st_i[2*W +: W]), .b_i(st_i[3*W +: W]), .a_o(m2), .b_o(m3)
  );

  // fixed reorder: outer odd words trade places
  assign st_o = {m1, m2, m3, m0};
endmodule

// File: rtl/tf8_core.sv
module tf8_core #(
  parameter int WORD_W = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [4*WORD_W-1:0]     in_state,
  input  logic [4*WORD_W-1:0]     in_sk0,
  input  logic [4*WORD_W-1:0]     in_sk1,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [4*WORD_W-1:0]     out_state
);
  localparam int NW      = tf8_pkg::NUM_WORDS;
  localparam int STATE_W = NW * WORD_W;
  localparam int ROUNDS  = tf8_pkg::GROUP_ROUNDS;
  localparam int STRIDE  = tf8_pkg::KEY_STRIDE;

  logic [STATE_W-1:0] pre  [ROUNDS+1];
  logic [STATE_W-1:0] keyd [ROUNDS];
  logic [STATE_W-1:0] res_q;
  logic               vld_q;
  logic               take;

  assign pre[0] = in_state;

  for (genvar d = 0; d < ROUNDS; d++) begin : g_rnd
    if (d % STRIDE == 0) begin : g_inj
      tf8_keyadd #(.W(WORD_W), .N(NW)) u_add (
        .st_i (pre[d]),
        .key_i((d == 0) ? in_sk0 : in_sk1),
        .st_o (keyd[d])
      );
    end else begin : g_pass
      assign keyd[d] = pre[d];
    end
    tf8_round #(.W(WORD_W), .RIDX(d)) u_round (
      .st_i(keyd[d]),
      .st_o(pre[d+1])
    );
  end

  assign in_ready = !vld_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else if (take) begin
      vld_q <= 1'b1;
      res_q <= pre[ROUNDS];
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_state = res_q;
endmodule

// File: rtl/tf8_chk.sv
module tf8_chk #(
  parameter int STATE_W = 256
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [STATE_W-1:0] in_state,
  input logic [STATE_W-1:0] in_sk0,
  input logic [STATE_W-1:0] in_sk1,
  input logic               out_valid,
  input logic               out_ready,
  input logic [STATE_W-1:0] out_state
);
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready));

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_state)));

  a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r8_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r9_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_state == '0 && in_sk0 == '0 && in_sk1 == '0)
      |=> (out_state == '0));

  a_r10_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

bind tf8_core tf8_chk #(.STATE_W(STATE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_state (in_state),
  .in_sk0   (in_sk0),
  .in_sk1   (in_sk1),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_state(out_state)
);

// File: tb/sim_tf8_core.sv
`timescale 1ns/1ps
module sim_tf8_core;
  localparam int WW = 64;
  localparam int SW = 4 * WW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [SW-1:0] in_state = '0;
  logic [SW-1:0] in_sk0 = '0;
  logic [SW-1:0] in_sk1 = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [SW-1:0] out_state;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  tf8_core #(.WORD_W(WW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_state(in_state), .in_sk0(in_sk0), .in_sk1(in_sk1),
    .out_valid(out_valid), .out_ready(out_ready), .out_state(out_state)
  );

  // R3 distances as stated in the requirements
  localparam int RA [8] = '{14, 52, 23, 5, 25, 46, 58, 32};
  localparam int RB [8] = '{16, 57, 40, 37, 33, 12, 22, 32};

  typedef struct packed {
    logic [SW-1:0] st;
    logic [SW-1:0] k0;
    logic [SW-1:0] k1;
    logic          zero_exp;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{st: '0, k0: '0, k1: '0, zero_exp: 1'b1},
    '{st: {64'h0, 64'h0, 64'h0, 64'h1}, k0: '0, k1: '0, zero_exp: 1'b0},
    '{st: {4{64'hFFFF_FFFF_FFFF_FFFF}}, k0: {4{64'h1}}, k1: '0, zero_exp: 1'b1},
    '{st: {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h0F0F_0F0F_0F0F_0F0F, 64'h8000_0000_0000_0001},
      k0: {64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, 64'h3333_3333_3333_3333, 64'h4444_4444_4444_4444},
      k1: {64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 64'hDEAD_BEEF_CAFE_F00D, 64'h7FFF_FFFF_FFFF_FFFF},
      zero_exp: 1'b0},
    '{st: {64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
      k0: {64'h0, 64'h1, 64'h0, 64'h1}, k1: {4{64'hFFFF_FFFF_FFFF_FFFF}}, zero_exp: 1'b0},
    '{st: {64'h0, 64'h0, 64'h8000_0000_0000_0000, 64'h0}, k0: '0, k1: {64'h1, 64'h0, 64'h0, 64'h0},
      zero_exp: 1'b0}
  };

  function automatic logic [63:0] rotl(input logic [63:0] x, input int r);
    return (x << r) | (x >> (64 - r));
  endfunction

  function automatic logic [SW-1:0] model(input logic [SW-1:0] st,
                                          input logic [SW-1:0] k0,
                                          input logic [SW-1:0] k1);
    logic [63:0] v [4];
    logic [63:0] t;
    for (int i = 0; i < 4; i++) v[i] = st[64*i +: 64];
    for (int d = 0; d < 8; d++) begin
      if (d == 0) for (int i = 0; i < 4; i++) v[i] = v[i] + k0[64*i +: 64];
      if (d == 4) for (int i = 0; i < 4; i++) v[i] = v[i] + k1[64*i +: 64];
      v[0] = v[0] + v[1];
      v[1] = rotl(v[1], RA[d]) ^ v[0];
      v[2] = v[2] + v[3];
      v[3] = rotl(v[3], RB[d]) ^ v[2];
      t = v[1]; v[1] = v[3]; v[3] = t;
    end
    return {v[3], v[2], v[1], v[0]};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [SW-1:0] act, input logic [SW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // present one beat at a falling edge, hold until taken, then release
  task automatic send(input logic [SW-1:0] st, input logic [SW-1:0] k0,
                      input logic [SW-1:0] k1);
    @(negedge clk);
    in_valid = 1'b1; in_state = st; in_sk0 = k0; in_sk1 = k1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] e;
    logic [SW-1:0] a_st, a_k0, a_k1, b_st, b_k0, b_k1;

    // R1 reset state
    #23;
    check(!out_valid && in_ready, "R1 during reset", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 after release", {out_valid, in_ready}, 2'b01);

    // table walk: R2 R3 R4 R5 R6 R9
    for (int i = 0; i < 6; i++) begin
      send(TBL[i].st, TBL[i].k0, TBL[i].k1);
      e = model(TBL[i].st, TBL[i].k0, TBL[i].k1);
      check(out_valid, "R6 valid one cycle after accept", {255'b0, out_valid}, 1);
      check(out_state == e, "R2 R3 R4 R5 table result", out_state, e);
      if (TBL[i].zero_exp)
        check(out_state == '0, "R9 zero result", out_state, '0);
    end

    // R10 drain: no new beat, out_ready high
    @(negedge clk);
    check(!out_valid, "R10 drain clears valid", {255'b0, out_valid}, 0);

    // R9 cancelling subkey, arbitrary state
    a_st = {64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'hAAAA_5555_AAAA_5555, 64'h1};
    a_k0 = {-a_st[255:192], -a_st[191:128], -a_st[127:64], -a_st[63:0]};
    send(a_st, a_k0, '0);
    check(out_state == '0, "R9 cancelled state", out_state, '0);

    // random operands, R2 R3 R4 R5
    for (int i = 0; i < 40; i++) begin
      a_st = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      a_k0 = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      a_k1 = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      send(a_st, a_k0, a_k1);
      e = model(a_st, a_k0, a_k1);
      check(out_state == e, "R5 random result", out_state, e);
    end

    // back-pressure: R7, R10 ignore, R8 refill
    a_st = {4{64'h0102_0304_0506_0708}}; a_k0 = {4{64'h9}}; a_k1 = {4{64'h77}};
    b_st = {4{64'hF0E0_D0C0_B0A0_9080}}; b_k0 = {4{64'h3}}; b_k1 = {4{64'h55}};
    @(negedge clk);
    out_ready = 1'b0;
    send(a_st, a_k0, a_k1);
    e = model(a_st, a_k0, a_k1);
    in_valid = 1'b1; in_state = b_st; in_sk0 = b_k0; in_sk1 = b_k1;
    for (int c = 0; c < 3; c++) begin
      check(out_valid && out_state == e, "R7 result held", out_state, e);
      check(!in_ready, "R7 upstream stalled", {255'b0, in_ready}, 0);
      @(negedge clk);
    end
    check(out_state == e, "R10 stalled input ignored", out_state, e);
    out_ready = 1'b1;
    #1;
    check(in_ready, "R8 ready while draining", {255'b0, in_ready}, 1);
    @(negedge clk);
    in_valid = 1'b0;
    e = model(b_st, b_k0, b_k1);
    check(out_valid && out_state == e, "R8 refill same cycle", out_state, e);
    @(negedge clk);
    check(!out_valid, "R10 drain after refill", {255'b0, out_valid}, 0);

    // R1 reset mid-stream
    out_ready = 1'b0;
    send(a_st, a_k0, a_k1);
    rst_n = 1'b0;
    #1;
    check(!out_valid && in_ready, "R1 async reset", {out_valid, in_ready}, 2'b01);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);

    done = 1'b1;
    report();
    $finish;
  end
endmodule